// File: doc/BRIEF.md
# Processor status flag register unit

This block holds the 8-bit status byte of a small 8-bit CPU and applies every flag change to it. Each cycle it takes at most one result update from the datapath: an arithmetic result, a shift or rotate result, a data-transfer result, or a bit-test result. It can also take one explicit flag command, a stack push request and a restore of the byte from the stack. The new byte is visible on the cycle after the edge that takes the update in. The ALU, the decimal correction, the decoder and the stack memory sit outside the block, and they drive it through one-cycle command inputs.

The block also forms the byte to be written to the stack for an interrupt entry. The break position of that byte is 1 only for a software break, while the live copy of that bit is always 0. The interrupt-disable flag is brought out as a mask for the interrupt controller. A combinational qualifier tells the consumer when the zero, overflow and negative values being produced are not meaningful, which is the case for arithmetic in decimal mode.

Top module: `psr_unit`

## Requirements
- R1: Asynchronous reset drives status_o to 0x04: only I is set. The bit layout is C=0, Z=1, I=2, D=3, B=4, T=5, V=6, N=7.
- R2: With upd_op_i=1 (arithmetic), at the next edge C takes carry_i, V takes ovf_i, Z becomes 1 exactly when result_i is 0x00, and N takes result_i[7].
- R3: With upd_op_i=2 (shift or rotate), at the next edge C takes carry_i, Z becomes (result_i==0) and N takes result_i[7]. All other flags are kept.
- R4: With upd_op_i=3 (data transfer), Z becomes (result_i==0) and N takes result_i[7]. C and V are kept, and carry_i and ovf_i are ignored.
- R5: With upd_op_i=4 (bit test), V takes mem_i[6], N takes mem_i[7] and Z becomes (result_i==0). C is kept.
- R6: The setclr_i codes are 1 set C, 2 clear C, 3 set I, 4 clear I, 5 set D, 6 clear D, 7 set T, 8 clear T and 9 clear V. Code 0 and the codes above 9 do nothing, and so do upd_op_i values 0, 5, 6 and 7. No code sets V, and no code touches Z, B or N.
- R7: When a flag receives an explicit command and a result update in the same cycle, the command wins. The other flags still take the update.
- R8: restore_i loads restore_data_i with bit 4 forced to 0. It overrides every other source in that cycle, including the I set of a hardware push.
- R9: status_o[4] is always 0. push_data_o equals status_o with bit 4 replaced by push_brk_i, combinationally.
- R10: push_i with push_brk_i=0 (hardware interrupt) sets I at the next edge and wins over a clear-I command. push_i with push_brk_i=1 leaves I unchanged.
- R11: irq_mask_o always equals status_o[2].
- R12: flags_valid_o is 0 while upd_op_i=1 and D is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_op_i | input | 3 | Result update kind (0 none, 1 arithmetic, 2 shift, 3 transfer, 4 bit test) |
| result_i | input | 8 | Result byte of the operation |
| carry_i | input | 1 | Carry or borrow out |
| ovf_i | input | 1 | Signed overflow |
| mem_i | input | 8 | Memory operand of a bit test |
| setclr_i | input | 4 | Explicit flag command code |
| push_i | input | 1 | Status is being pushed for an interrupt entry |
| push_brk_i | input | 1 | The push is for a software break |
| restore_i | input | 1 | Load the status from restore_data_i |
| restore_data_i | input | 8 | Byte popped from the stack |
| status_o | output | 8 | Live status byte |
| push_data_o | output | 8 | Byte to write to the stack |
| irq_mask_o | output | 1 | Interrupt mask (I flag) |
| flags_valid_o | output | 1 | Z, V and N of the current update are meaningful |

## Verification
Register updates, restores and explicit commands appear on status_o one cycle after the edge that samples them. The bench drives each stimulus on a falling edge and reads status_o on the next falling edge, after exactly one rising edge. push_data_o, irq_mask_o and flags_valid_o are combinational, so they are checked in the same half cycle in which their inputs are driven, before any edge can change the stored byte. The effect of a push on I is then checked one falling edge later.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W = 8;
  localparam int unsigned BIT_C = 0;
  localparam int unsigned BIT_Z = 1;
  localparam int unsigned BIT_I = 2;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned BIT_B = 4;
  localparam int unsigned BIT_T = 5;
  localparam int unsigned BIT_V = 6;
  localparam int unsigned BIT_N = 7;
  localparam logic [PSR_W-1:0] PSR_RESET = PSR_W'(1) << BIT_I;
  localparam logic [PSR_W-1:0] B_MASK    = PSR_W'(1) << BIT_B;

  typedef enum logic [2:0] {
    UPD_NONE  = 3'd0,
    UPD_ARITH = 3'd1,
    UPD_SHIFT = 3'd2,
    UPD_XFER  = 3'd3,
    UPD_BIT   = 3'd4
  } upd_op_e;

  typedef enum logic [3:0] {
    SC_NONE  = 4'd0,
    SC_SET_C = 4'd1,
    SC_CLR_C = 4'd2,
    SC_SET_I = 4'd3,
    SC_CLR_I = 4'd4,
    SC_SET_D = 4'd5,
    SC_CLR_D = 4'd6,
    SC_SET_T = 4'd7,
    SC_CLR_T = 4'd8,
    SC_CLR_V = 4'd9
  } setclr_e;

  typedef struct packed {
    logic [PSR_W-1:0] mask;
    logic [PSR_W-1:0] val;
  } flag_upd_t;
endpackage

// File: rtl/psr_upd.sv
module psr_upd
  import psr_pkg::*;
(
  input  logic [2:0]       op_i,
  input  logic [PSR_W-1:0] result_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic [PSR_W-1:0] mem_i,
  input  logic             d_flag_i,
  output flag_upd_t        upd_o,
  output logic             flags_valid_o
);
  logic is_zero;
  assign is_zero = (result_i == '0);

  always_comb begin
    upd_o = '0;
    unique case (op_i)
      UPD_ARITH: begin
        upd_o.mask[BIT_C] = 1'b1; upd_o.val[BIT_C] = carry_i;
        upd_o.mask[BIT_Z] = 1'b1; upd_o.val[BIT_Z] = is_zero;
        upd_o.mask[BIT_V] = 1'b1; upd_o.val[BIT_V] = ovf_i;
        upd_o.mask[BIT_N] = 1'b1; upd_o.val[BIT_N] = result_i[PSR_W-1];
      end
      UPD_SHIFT: begin
        upd_o.mask[BIT_C] = 1'b1; upd_o.val[BIT_C] = carry_i;
        upd_o.mask[BIT_Z] = 1'b1; upd_o.val[BIT_Z] = is_zero;
        upd_o.mask[BIT_N] = 1'b1; upd_o.val[BIT_N] = result_i[PSR_W-1];
      end
      UPD_XFER: begin
        upd_o.mask[BIT_Z] = 1'b1; upd_o.val[BIT_Z] = is_zero;
        upd_o.mask[BIT_N] = 1'b1; upd_o.val[BIT_N] = result_i[PSR_W-1];
      end
      UPD_BIT: begin
        upd_o.mask[BIT_Z] = 1'b1; upd_o.val[BIT_Z] = is_zero;
        upd_o.mask[BIT_V] = 1'b1; upd_o.val[BIT_V] = mem_i[BIT_V];
        upd_o.mask[BIT_N] = 1'b1; upd_o.val[BIT_N] = mem_i[BIT_N];
      end
      default: upd_o = '0;
    endcase
  end

  // decimal add/subtract leaves Z, V, N meaningless
  assign flags_valid_o = !((op_i == UPD_ARITH) && d_flag_i);
endmodule

// File: rtl/psr_setclr.sv
module psr_setclr
  import psr_pkg::*;
(
  input  logic [3:0] setclr_i,
  input  logic       hw_push_i,
  output flag_upd_t  cmd_o
);
  always_comb begin
    cmd_o = '0;
    unique case (setclr_i)
      SC_SET_C: begin cmd_o.mask[BIT_C] = 1'b1; cmd_o.val[BIT_C] = 1'b1; end
      SC_CLR_C: begin cmd_o.mask[BIT_C] = 1'b1; cmd_o.val[BIT_C] = 1'b0; end
      SC_SET_I: begin cmd_o.mask[BIT_I] = 1'b1; cmd_o.val[BIT_I] = 1'b1; end
      SC_CLR_I: begin cmd_o.mask[BIT_I] = 1'b1; cmd_o.val[BIT_I] = 1'b0; end
      SC_SET_D: begin cmd_o.mask[BIT_D] = 1'b1; cmd_o.val[BIT_D] = 1'b1; end
      SC_CLR_D: begin cmd_o.mask[BIT_D] = 1'b1; cmd_o.val[BIT_D] = 1'b0; end
      SC_SET_T: begin cmd_o.mask[BIT_T] = 1'b1; cmd_o.val[BIT_T] = 1'b1; end
      SC_CLR_T: begin cmd_o.mask[BIT_T] = 1'b1; cmd_o.val[BIT_T] = 1'b0; end
      SC_CLR_V: begin cmd_o.mask[BIT_V] = 1'b1; cmd_o.val[BIT_V] = 1'b0; end
      default:  cmd_o = '0;
    endcase
    // interrupt entry masks further interrupts; beats a same-cycle clear
    if (hw_push_i) begin
      cmd_o.mask[BIT_I] = 1'b1;
      cmd_o.val[BIT_I]  = 1'b1;
    end
  end
endmodule

// File: rtl/psr_push_fmt.sv
module psr_push_fmt
  import psr_pkg::*;
(
  input  logic [PSR_W-1:0] status_i,
  input  logic             brk_i,
  output logic [PSR_W-1:0] push_o
);
  always_comb begin
    push_o        = status_i;
    push_o[BIT_B] = brk_i;
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       upd_op_i,
  input  logic [PSR_W-1:0] result_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic [PSR_W-1:0] mem_i,
  input  logic [3:0]       setclr_i,
  input  logic             push_i,
  input  logic             push_brk_i,
  input  logic             restore_i,
  input  logic [PSR_W-1:0] restore_data_i,
  output logic [PSR_W-1:0] status_o,
  output logic [PSR_W-1:0] push_data_o,
  output logic             irq_mask_o,
  output logic             flags_valid_o
);
  logic [PSR_W-1:0] psr_q, psr_d;
  flag_upd_t        upd, cmd;

  psr_upd i_upd (
    .op_i          (upd_op_i),
    .result_i      (result_i),
    .carry_i       (carry_i),
    .ovf_i         (ovf_i),
    .mem_i         (mem_i),
    .d_flag_i      (psr_q[BIT_D]),
    .upd_o         (upd),
    .flags_valid_o (flags_valid_o)
  );

  psr_setclr i_setclr (
    .setclr_i  (setclr_i),
    .hw_push_i (push_i && !push_brk_i),
    .cmd_o     (cmd)
  );

  psr_push_fmt i_push_fmt (
    .status_i (psr_q),
    .brk_i    (push_brk_i),
    .push_o   (push_data_o)
  );

  // per-flag merge: restore > command > result update > hold
  for (genvar b = 0; b < PSR_W; b++) begin : g_bit
    if (b == BIT_B) begin : g_brk
      assign psr_d[b] = 1'b0;
    end else begin : g_flag
      always_comb begin
        if (restore_i)        psr_d[b] = restore_data_i[b];
        else if (cmd.mask[b]) psr_d[b] = cmd.val[b];
        else if (upd.mask[b]) psr_d[b] = upd.val[b];
        else                  psr_d[b] = psr_q[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psr_q <= PSR_RESET;
    else         psr_q <= psr_d;
  end

  assign status_o   = psr_q;
  assign irq_mask_o = psr_q[BIT_I];
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk
  import psr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       upd_op_i,
  input logic [PSR_W-1:0] result_i,
  input logic             carry_i,
  input logic             ovf_i,
  input logic [PSR_W-1:0] mem_i,
  input logic [3:0]       setclr_i,
  input logic             push_i,
  input logic             push_brk_i,
  input logic             restore_i,
  input logic [PSR_W-1:0] restore_data_i,
  input logic [PSR_W-1:0] status_o,
  input logic [PSR_W-1:0] push_data_o,
  input logic             irq_mask_o,
  input logic             flags_valid_o
);
  assert_brk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[BIT_B] == 1'b0);

  assert_push_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_data_o[BIT_B] == push_brk_i) &&
    ((push_data_o & ~B_MASK) == (status_o & ~B_MASK)));

  assert_restore_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> status_o == ($past(restore_data_i) & ~B_MASK));

  assert_hw_push_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !push_brk_i && !restore_i) |=> status_o[BIT_I]);

  assert_clv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setclr_i == SC_CLR_V && !restore_i) |=> !status_o[BIT_V]);

  assert_xfer_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == UPD_XFER && !restore_i) |=>
      status_o[BIT_Z] == ($past(result_i) == '0));

  assert_mask_out_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_o == status_o[BIT_I]);

  assert_decimal_invalid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_op_i == UPD_ARITH && status_o[BIT_D]) |-> !flags_valid_o);
endmodule

bind psr_unit psr_unit_chk i_chk (.*);

// File: tb/test_psr_unit.sv
module test_psr_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] upd_op_i = '0;
  logic [7:0] result_i = '0;
  logic       carry_i = 1'b0;
  logic       ovf_i = 1'b0;
  logic [7:0] mem_i = '0;
  logic [3:0] setclr_i = '0;
  logic       push_i = 1'b0;
  logic       push_brk_i = 1'b0;
  logic       restore_i = 1'b0;
  logic [7:0] restore_data_i = '0;
  logic [7:0] status_o, push_data_o;
  logic       irq_mask_o, flags_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  psr_unit i_psr_unit (.*);

  // {op, setclr, result, carry, ovf, mem, expected status}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {3'd1, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h07}, // R2 zero, carry
    {3'd1, 4'd0, 8'h80, 1'b0, 1'b1, 8'h00, 8'hC4}, // R2 negative, overflow
    {3'd2, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00, 8'h47}, // R3 V kept
    {3'd3, 4'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 8'hC5}, // R4 C kept
    {3'd4, 4'd0, 8'h00, 1'b0, 1'b0, 8'h40, 8'h47}, // R5
    {3'd4, 4'd0, 8'h01, 1'b0, 1'b0, 8'h80, 8'h85}, // R5
    {3'd0, 4'd5, 8'h00, 1'b0, 1'b0, 8'h00, 8'h8D}, // R6 set D
    {3'd0, 4'd7, 8'h00, 1'b0, 1'b0, 8'h00, 8'hAD}, // R6 set T
    {3'd0, 4'd4, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA9}, // R6 clear I
    {3'd0, 4'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'hA8}, // R6 clear C
    {3'd1, 4'd1, 8'h01, 1'b0, 1'b1, 8'h00, 8'h69}, // R7 set C beats carry 0
    {3'd0, 4'd9, 8'h00, 1'b0, 1'b0, 8'h00, 8'h29}, // R6 clear V
    {3'd0, 4'd8, 8'h00, 1'b0, 1'b0, 8'h00, 8'h09}, // R6 clear T
    {3'd0, 4'd6, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01}, // R6 clear D
    {3'd0, 4'd3, 8'h00, 1'b0, 1'b0, 8'h00, 8'h05}, // R6 set I
    {3'd5, 4'd12, 8'h00, 1'b1, 1'b1, 8'hFF, 8'h05} // R6 unused codes ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    upd_op_i = '0; setclr_i = '0; push_i = 1'b0; push_brk_i = 1'b0;
    restore_i = 1'b0; result_i = '0; carry_i = 1'b0; ovf_i = 1'b0; mem_i = '0;
  endtask

  task automatic do_restore(input logic [7:0] d);
    @(negedge clk_i);
    idle();
    restore_i = 1'b1; restore_data_i = d;
    @(negedge clk_i);
    restore_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    push_brk_i = 1'b1;
    #1;
    check("R1 reset status", status_o, 8'h04);
    check("R11 reset mask", {7'd0, irq_mask_o}, 8'h01);
    check("R9 brk push byte", push_data_o, 8'h14);
    push_brk_i = 1'b0;
    rst_ni = 1'b1;

    // table walk: drive on a falling edge, read one falling edge later
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      if (k > 0) check($sformatf("R2-table vec %0d", k - 1), status_o, VEC[k-1][7:0]);
      {upd_op_i, setclr_i, result_i, carry_i, ovf_i, mem_i} = VEC[k][32:8];
    end
    @(negedge clk_i);
    check("R6 table last vec", status_o, VEC[NV-1][7:0]);
    idle();

    // R12: decimal mode qualifier
    do_restore(8'h08);
    check("R8 restore D", status_o, 8'h08);
    upd_op_i = 3'd1; #1;
    check("R12 decimal arith invalid", {7'd0, flags_valid_o}, 8'h00);
    upd_op_i = 3'd3; #1;
    check("R12 transfer valid", {7'd0, flags_valid_o}, 8'h01);
    upd_op_i = 3'd0;

    // R8: restore beats command and update
    @(negedge clk_i);
    restore_i = 1'b1; restore_data_i = 8'hFF;
    setclr_i = 4'd2; upd_op_i = 3'd1; carry_i = 1'b0; result_i = 8'h00;
    @(negedge clk_i);
    idle();
    check("R8 restore priority, B forced 0", status_o, 8'hEF);
    check("R11 mask follows I", {7'd0, irq_mask_o}, 8'h01);
    do_restore(8'h10);
    check("R8 restored B stays 0", status_o, 8'h00);
    check("R11 mask low", {7'd0, irq_mask_o}, 8'h00);

    // R10: hardware push sets I, beats clear-I
    push_i = 1'b1; push_brk_i = 1'b0; setclr_i = 4'd4; #1;
    check("R9 hw push byte", push_data_o, 8'h00);
    @(negedge clk_i);
    idle();
    check("R10 hw push sets I", status_o, 8'h04);
    check("R11 mask after push", {7'd0, irq_mask_o}, 8'h01);

    // R10: BRK push leaves I
    do_restore(8'h00);
    push_i = 1'b1; push_brk_i = 1'b1; #1;
    check("R9 brk push byte set", push_data_o, 8'h10);
    @(negedge clk_i);
    idle();
    check("R10 brk push keeps I", status_o, 8'h00);

    // R8: restore beats hw push I set
    @(negedge clk_i);
    restore_i = 1'b1; restore_data_i = 8'h00; push_i = 1'b1;
    @(negedge clk_i);
    idle();
    check("R8 restore over hw push", status_o, 8'h00);

    // R1: asynchronous reset mid-run
    do_restore(8'hC3);
    #2 rst_ni = 1'b0;
    #1;
    check("R1 async reset", status_o, 8'h04);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule